// File: doc/BRIEF.md
# Word-Mode Serial Flash Program Sequencer

This block writes an arbitrary byte range into a serial NOR flash that offers an auto-address-increment word programming mode. Once started with a start address and a length, it pulls the data bytes from a valid/ready byte stream. It then drives the SPI pins through a full programming sequence. A write-enable opens the sequence. An odd start address is handled with one single-byte program. The body of the range is sent as two-byte word frames. Only the first word frame carries the address; the flash advances the address itself for the later ones.

A write-disable closes the word phase. A single byte left over at the end is written with its own write-enable, single-byte program and write-disable. After every program frame the block reads the flash status register repeatedly until the write-in-progress bit clears. If that bit stays set for too many reads, the whole sequence is aborted with an error. A counter reports how many data bytes have been taken from the stream.

Top module: `aaiw_prog_seq`

## Requirements
- R1: Every run with a non-zero length begins with exactly one write-enable frame consisting of the single opcode byte 0x06.
- R2: When the start address is odd, the next frame is a single-byte program: opcode 0x02, the address in three bytes most significant first, then one data byte.
- R3: The first word frame is opcode 0xAD, the (even) current address in three bytes most significant first, then two data bytes.
- R4: Every later word frame is opcode 0xAD followed by two data bytes only. Words are issued while at least two bytes remain, and the address advances by two per word.
- R5: After each program frame (0x02 or 0xAD), status-read frames (opcode 0x05 plus one received byte) are repeated until the received bit 0 is clear, and no other frame is sent in between.
- R6: After the word phase, even when it sent no word, a write-disable frame (single byte 0x04) is sent, followed by status polling.
- R7: When exactly one byte remains after the word phase, the block sends a write-enable frame. It then sends a single-byte program at the following address, polls status, and ends with a write-disable frame that is not followed by polling.
- R8: `bytes_sent` counts data bytes accepted from the stream. It clears on start, never steps by more than one per cycle, and equals the length when a run ends without error.
- R9: When the status read shows bit 0 set on MAX_POLLS consecutive reads, the run stops with `error` and `done` high, and no further frame is sent.
- R10: A start with length zero raises `done` one cycle later, with no frame, no error and a count of zero.
- R11: The SPI interface is mode 0. `spi_sclk` idles low, `spi_cs_n` is high outside frames and whenever the block is idle, and bytes go most significant bit first. Output data changes while the clock is low and is sampled on the rising clock edge.
- R12: `wr_ready` is high only while a data byte slot of an open frame is waiting. Bytes are used in stream order, and a stall on `wr_valid` holds the frame without losing or reordering data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted while idle) |
| start_addr | input | 8*ADDR_BYTES | First flash address of the range |
| byte_len | input | LEN_W | Number of bytes to write |
| wr_data | input | 8 | Stream data byte |
| wr_valid | input | 1 | Stream byte available |
| wr_ready | output | 1 | Block takes the stream byte this cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished; held until next start |
| error | output | 1 | Last run aborted on status timeout |
| bytes_sent | output | LEN_W | Data bytes accepted in the current run |

## Verification
The bench builds the block with HALF_DIV of 1, so each SPI bit takes only two clocks and a dozen full runs fit in a short simulation. It sets MAX_POLLS to 8, which makes the status-timeout abort reachable with a flash model that never clears its busy bit. The flash model reports busy for two status reads after each program frame. This exercises repeated polling without long waits. Odd and even starts, single-byte ranges and stalls on the stream are all mixed through the vector table.

// File: rtl/aaiw_pkg.sv
// Shared opcodes and state types for the word-mode flash program sequencer.
package aaiw_pkg;
    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_BYTE_PG = 8'h02;
    localparam logic [7:0] OP_WORD_PG = 8'hAD;
    localparam logic [7:0] OP_STATUS  = 8'h05;

    typedef enum logic [2:0] {
        FK_WR_EN,
        FK_WR_DIS,
        FK_BYTE,
        FK_WORD_FIRST,
        FK_WORD_NEXT,
        FK_STATUS
    } frame_kind_t;

    typedef enum logic [3:0] {
        Q_IDLE,
        Q_WREN,
        Q_LEAD,
        Q_WORD,
        Q_WRDI,
        Q_POLL,
        Q_TWREN,
        Q_TBYTE,
        Q_TWRDI
    } seq_state_t;

    typedef enum logic [1:0] {
        RET_WORDS,
        RET_TAIL,
        RET_END
    } poll_ret_t;
endpackage

// File: rtl/aaiw_spi_byte.sv
// Mode-0 SPI byte shifter.
// Shifts one byte out MSB first and one byte in, one bit per 2*HALF_DIV clocks.
// Assumes go is only raised while busy is low; sclk ends every byte low.
module aaiw_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       busy,
    output logic       done
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic [2:0]    bit_q;
    logic [DW-1:0] div_q;
    logic          sclk_q;
    logic          busy_q;
    logic          done_q;

    // Clock divider, shift register and bit counter for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            div_q  <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    sh_q   <= tx;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q == DW'(HALF_DIV - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign sclk = sclk_q;
    assign mosi = sh_q[7];
    assign rx   = rx_q;
    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/aaiw_frame_tx.sv
// Frame sender: opens chip select, emits the bytes of one command frame of the
// requested kind, pulls data bytes from the stream where the frame has data slots,
// closes chip select and pulses frame_done. Assumes start only while idle.
module aaiw_frame_tx
    import aaiw_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int HALF_DIV   = 2,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  frame_kind_t       kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    input  logic              data_valid,
    output logic              data_ready,
    output logic              data_take,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [7:0]        status,
    output logic              frame_done
);
    typedef enum logic [1:0] {T_IDLE, T_LOAD, T_SHIFT, T_END} tx_state_t;

    tx_state_t         st_q;
    frame_kind_t       kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        idx_q;
    logic              cs_q;
    logic [3:0]        last_idx;
    logic              is_data;
    logic [7:0]        cmd_byte;
    logic [7:0]        abyte;
    logic [7:0]        abytes [ADDR_BYTES];
    logic              go;
    logic              eng_done;
    logic              eng_busy;
    logic [7:0]        eng_rx;

    // Address bytes, most significant first.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
        assign abytes[g] = addr_q[ADDR_W-1-8*g -: 8];
    end

    // Frame length per kind (index of its last byte).
    always_comb begin
        case (kind_q)
            FK_BYTE:       last_idx = 4'(ADDR_BYTES + 1);
            FK_WORD_FIRST: last_idx = 4'(ADDR_BYTES + 2);
            FK_WORD_NEXT:  last_idx = 4'd2;
            FK_STATUS:     last_idx = 4'd1;
            default:       last_idx = 4'd0;
        endcase
    end

    // Address byte for the current byte index.
    always_comb begin
        abyte = 8'h00;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx_q == 4'(k + 1)) abyte = abytes[k];
        end
    end

    // Content of the current byte slot: opcode, address, dummy or data.
    always_comb begin
        is_data  = 1'b0;
        cmd_byte = 8'h00;
        if (idx_q == 4'd0) begin
            case (kind_q)
                FK_WR_EN:      cmd_byte = OP_WR_EN;
                FK_WR_DIS:     cmd_byte = OP_WR_DIS;
                FK_BYTE:       cmd_byte = OP_BYTE_PG;
                FK_WORD_FIRST: cmd_byte = OP_WORD_PG;
                FK_WORD_NEXT:  cmd_byte = OP_WORD_PG;
                default:       cmd_byte = OP_STATUS;
            endcase
        end else begin
            case (kind_q)
                FK_BYTE, FK_WORD_FIRST: begin
                    if (idx_q <= 4'(ADDR_BYTES)) cmd_byte = abyte;
                    else                         is_data  = 1'b1;
                end
                FK_WORD_NEXT: is_data = 1'b1;
                default:      cmd_byte = 8'h00;
            endcase
        end
    end

    assign data_ready = (st_q == T_LOAD) && is_data;
    assign data_take  = data_ready && data_valid;
    assign go         = (st_q == T_LOAD) && (!is_data || data_valid);

    // Frame-level control: byte index and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= T_IDLE;
            kind_q <= FK_WR_EN;
            addr_q <= '0;
            idx_q  <= '0;
            cs_q   <= 1'b1;
        end else begin
            case (st_q)
                T_IDLE: if (start) begin
                    kind_q <= kind;
                    addr_q <= addr;
                    idx_q  <= '0;
                    cs_q   <= 1'b0;
                    st_q   <= T_LOAD;
                end
                T_LOAD: if (go) st_q <= T_SHIFT;
                T_SHIFT: if (eng_done) begin
                    if (idx_q == last_idx) begin
                        cs_q <= 1'b1;
                        st_q <= T_END;
                    end else begin
                        idx_q <= idx_q + 4'd1;
                        st_q  <= T_LOAD;
                    end
                end
                default: st_q <= T_IDLE;
            endcase
        end
    end

    aaiw_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .tx   (is_data ? data_in : cmd_byte),
        .miso (miso),
        .sclk (sclk),
        .mosi (mosi),
        .rx   (eng_rx),
        .busy (eng_busy),
        .done (eng_done)
    );

    assign cs_n       = cs_q;
    assign status     = eng_rx;
    assign frame_done = (st_q == T_END);
endmodule

// File: rtl/aaiw_prog_seq.sv
// Word-mode flash program sequencer (top).
// Orders the frames of one programming run: write-enable, optional leading
// single byte, word frames, write-disable, optional trailing single byte, with
// status polling after each program frame and an abort after MAX_POLLS busy reads.
// Assumes start is only acted on while idle and the flash is ready at start.
module aaiw_prog_seq
    import aaiw_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int LEN_W      = 16,
    parameter int HALF_DIV   = 2,
    parameter int MAX_POLLS  = 4096,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int PW        = $clog2(MAX_POLLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [LEN_W-1:0]  bytes_sent
);
    seq_state_t        st_q;
    poll_ret_t         ret_q;
    logic              launch_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              first_q;
    logic [PW-1:0]     polls_q;
    logic              done_q;
    logic              err_q;
    logic [LEN_W-1:0]  cnt_q;
    frame_kind_t       kind;
    logic              fdone;
    logic              ftake;
    logic [7:0]        fstatus;
    logic              two_left;

    assign two_left = (rem_q >= LEN_W'(2));

    // Frame kind for the current sequencer state.
    always_comb begin
        case (st_q)
            Q_LEAD, Q_TBYTE: kind = FK_BYTE;
            Q_WORD:          kind = first_q ? FK_WORD_FIRST : FK_WORD_NEXT;
            Q_WRDI, Q_TWRDI: kind = FK_WR_DIS;
            Q_POLL:          kind = FK_STATUS;
            default:         kind = FK_WR_EN;
        endcase
    end

    // Sequencer: picks the next frame when the current one completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= Q_IDLE;
            ret_q    <= RET_WORDS;
            launch_q <= 1'b0;
            addr_q   <= '0;
            rem_q    <= '0;
            first_q  <= 1'b1;
            polls_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cnt_q    <= '0;
        end else begin
            launch_q <= 1'b0;
            if (ftake) cnt_q <= cnt_q + LEN_W'(1);
            case (st_q)
                Q_IDLE: if (start) begin
                    addr_q  <= start_addr;
                    rem_q   <= byte_len;
                    cnt_q   <= '0;
                    err_q   <= 1'b0;
                    first_q <= 1'b1;
                    if (byte_len == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        done_q   <= 1'b0;
                        st_q     <= Q_WREN;
                        launch_q <= 1'b1;
                    end
                end
                Q_WREN: if (fdone) begin
                    launch_q <= 1'b1;
                    if (addr_q[0])     st_q <= Q_LEAD;
                    else if (two_left) st_q <= Q_WORD;
                    else               st_q <= Q_WRDI;
                end
                Q_LEAD: if (fdone) begin
                    addr_q   <= addr_q + ADDR_W'(1);
                    rem_q    <= rem_q - LEN_W'(1);
                    polls_q  <= '0;
                    ret_q    <= RET_WORDS;
                    st_q     <= Q_POLL;
                    launch_q <= 1'b1;
                end
                Q_WORD: if (fdone) begin
                    addr_q   <= addr_q + ADDR_W'(2);
                    rem_q    <= rem_q - LEN_W'(2);
                    first_q  <= 1'b0;
                    polls_q  <= '0;
                    ret_q    <= RET_WORDS;
                    st_q     <= Q_POLL;
                    launch_q <= 1'b1;
                end
                Q_WRDI: if (fdone) begin
                    polls_q  <= '0;
                    ret_q    <= RET_TAIL;
                    st_q     <= Q_POLL;
                    launch_q <= 1'b1;
                end
                Q_POLL: if (fdone) begin
                    if (fstatus[0]) begin
                        if (polls_q == PW'(MAX_POLLS - 1)) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                            st_q   <= Q_IDLE;
                        end else begin
                            polls_q  <= polls_q + PW'(1);
                            launch_q <= 1'b1;
                        end
                    end else begin
                        case (ret_q)
                            RET_WORDS: begin
                                st_q     <= two_left ? Q_WORD : Q_WRDI;
                                launch_q <= 1'b1;
                            end
                            RET_TAIL: begin
                                if (rem_q == LEN_W'(1)) begin
                                    st_q     <= Q_TWREN;
                                    launch_q <= 1'b1;
                                end else begin
                                    done_q <= 1'b1;
                                    st_q   <= Q_IDLE;
                                end
                            end
                            default: begin
                                st_q     <= Q_TWRDI;
                                launch_q <= 1'b1;
                            end
                        endcase
                    end
                end
                Q_TWREN: if (fdone) begin
                    st_q     <= Q_TBYTE;
                    launch_q <= 1'b1;
                end
                Q_TBYTE: if (fdone) begin
                    addr_q   <= addr_q + ADDR_W'(1);
                    rem_q    <= rem_q - LEN_W'(1);
                    polls_q  <= '0;
                    ret_q    <= RET_END;
                    st_q     <= Q_POLL;
                    launch_q <= 1'b1;
                end
                Q_TWRDI: if (fdone) begin
                    done_q <= 1'b1;
                    st_q   <= Q_IDLE;
                end
                default: st_q <= Q_IDLE;
            endcase
        end
    end

    aaiw_frame_tx #(
        .ADDR_BYTES(ADDR_BYTES),
        .HALF_DIV  (HALF_DIV)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch_q),
        .kind      (kind),
        .addr      (addr_q),
        .data_in   (wr_data),
        .data_valid(wr_valid),
        .data_ready(wr_ready),
        .data_take (ftake),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso),
        .status    (fstatus),
        .frame_done(fdone)
    );

    assign busy       = (st_q != Q_IDLE);
    assign done       = done_q;
    assign error      = err_q;
    assign bytes_sent = cnt_q;
endmodule

// File: rtl/aaiw_prog_seq_chk.sv
// Port-level property checker for the word-mode program sequencer, bound to the top.
module aaiw_prog_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] byte_len,
    input logic             wr_ready,
    input logic             spi_cs_n,
    input logic             spi_sclk,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [LEN_W-1:0] bytes_sent
);
    logic [LEN_W-1:0] len_cap;

    // Length of the run in progress, captured when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                len_cap <= '0;
        else if (start && !busy)   len_cap <= byte_len;
    end

    a_r11_sclk_low_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    a_r11_cs_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    a_r12_ready_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n);

    a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bytes_sent <= len_cap));

    a_r8_count_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (bytes_sent == $past(bytes_sent) || bytes_sent == $past(bytes_sent) + LEN_W'(1)));

    a_r8_full_count_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !error) |-> (bytes_sent == len_cap));

    a_r10_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_len == '0) |=> (done && !busy && !error && bytes_sent == '0));
endmodule

bind aaiw_prog_seq aaiw_prog_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .byte_len  (byte_len),
    .wr_ready  (wr_ready),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .bytes_sent(bytes_sent)
);

// File: tb/aaiw_prog_seq_bench.sv
module aaiw_prog_seq_bench;
    localparam int BUSY_N = 2;
    localparam int NVEC   = 8;

    // {stall, start address, length}
    localparam logic [40:0] VTAB [NVEC] = '{
        {1'b0, 24'h000100, 16'd4},
        {1'b1, 24'h000101, 16'd4},
        {1'b0, 24'h000101, 16'd1},
        {1'b0, 24'h000100, 16'd1},
        {1'b1, 24'h012303, 16'd5},
        {1'b0, 24'h0000FE, 16'd2},
        {1'b0, 24'hABCDEF, 16'd3},
        {1'b1, 24'h000010, 16'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] byte_len = '0;
    logic [7:0]  wr_data;
    logic        wr_valid;
    logic        wr_ready;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic        busy, done, error;
    logic [15:0] bytes_sent;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int sidx = 0;
    bit stall = 0;
    bit hang = 0;
    int sclk_bad = 0;

    always #4 clk = ~clk;

    aaiw_prog_seq #(
        .ADDR_BYTES(3), .LEN_W(16), .HALF_DIV(1), .MAX_POLLS(8)
    ) u_aaiw_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .done(done),
        .error(error), .bytes_sent(bytes_sent)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    // Byte stream source with optional stalls.
    assign wr_data  = pat(sidx);
    assign wr_valid = !(stall && ((cyc % 8) < 4));
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_valid && wr_ready) sidx <= sidx + 1;
    end

    // Flash model: collects frames, answers status reads.
    logic [7:0] m_sh = '0;
    int         m_bits = 0;
    logic [7:0] fr [16];
    int         fr_n = 0;
    int         busy_left = 0;
    logic [7:0] lg [256];
    int         lg_n = 0;
    logic [7:0] ex [256];
    int         ex_n = 0;
    logic [7:0] st_byte;

    assign st_byte  = {7'b0, (busy_left != 0) || hang};
    assign spi_miso = (!spi_cs_n && fr_n == 1 && fr[0] == 8'h05) ? st_byte[3'(7 - m_bits)] : 1'b0;

    always @(negedge spi_cs_n) begin
        m_bits = 0;
        fr_n   = 0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            m_sh   = {m_sh[6:0], spi_mosi};
            m_bits = m_bits + 1;
            if (m_bits == 8) begin
                if (fr_n < 16) fr[fr_n] = m_sh;
                fr_n   = fr_n + 1;
                m_bits = 0;
            end
        end
    end

    always @(posedge spi_cs_n) begin
        if (fr_n > 0) begin
            if (fr[0] == 8'h05) begin
                if (lg_n < 256) lg[lg_n] = 8'h05;
                lg_n = lg_n + 1;
                if (busy_left > 0) busy_left = busy_left - 1;
            end else begin
                for (int i = 0; i < fr_n && i < 16; i++) begin
                    if (lg_n < 256) lg[lg_n] = fr[i];
                    lg_n = lg_n + 1;
                end
                if (fr[0] == 8'h02 || fr[0] == 8'hAD) busy_left = BUSY_N;
            end
        end
    end

    // Clock must stay low outside frames (R11).
    always @(negedge clk) if (rst_n && spi_cs_n && spi_sclk) sclk_bad <= sclk_bad + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b);
        if (ex_n < 256) ex[ex_n] = b;
        ex_n++;
    endtask

    task automatic push_addr(input logic [23:0] a);
        push(a[23:16]); push(a[15:8]); push(a[7:0]);
    endtask

    task automatic push_polls();
        for (int i = 0; i <= BUSY_N; i++) push(8'h05);
    endtask

    // Expected frame log built from the requirements.
    task automatic build_exp(input logic [23:0] a0, input int n);
        logic [23:0] a = a0;
        int r = n;
        int k = 0;
        bit first = 1;
        ex_n = 0;
        if (n == 0) return;
        push(8'h06);
        if (a[0]) begin
            push(8'h02); push_addr(a); push(pat(k)); k++;
            push_polls(); a = a + 24'd1; r--;
        end
        while (r >= 2) begin
            push(8'hAD);
            if (first) push_addr(a);
            push(pat(k)); push(pat(k + 1)); k += 2;
            push_polls(); first = 0; a = a + 24'd2; r -= 2;
        end
        push(8'h04); push(8'h05);
        if (r == 1) begin
            push(8'h06); push(8'h02); push_addr(a); push(pat(k));
            push_polls(); push(8'h04);
        end
    endtask

    task automatic compare_log(input string tag);
        int bad = -1;
        check(lg_n == ex_n, tag, "frame byte count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n && i < 256; i++)
            if (bad < 0 && lg[i] !== ex[i]) bad = i;
        if (bad >= 0) check(0, tag, $sformatf("frame byte %0d", bad), lg[bad], ex[bad]);
        else          check(1, tag, "frame bytes", 0, 0);
    endtask

    task automatic launch(input logic [23:0] a, input logic [15:0] n);
        lg_n = 0; busy_left = 0; sidx = 0;
        @(negedge clk);
        start_addr = a; byte_len = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            if (done && !busy) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R11, R8).
        check(spi_cs_n === 1'b1, "R11", "cs_n in reset", spi_cs_n, 1);
        check(spi_sclk === 1'b0, "R11", "sclk in reset", spi_sclk, 0);
        check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R9", "flags in reset",
              {busy, done, error}, 0);
        check(bytes_sent === 16'd0, "R8", "count in reset", bytes_sent, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R4 R5 R6 R7 frame order, R8 count, R12 stalls.
        for (int v = 0; v < NVEC; v++) begin
            stall = VTAB[v][40];
            build_exp(VTAB[v][39:16], int'(VTAB[v][15:0]));
            launch(VTAB[v][39:16], VTAB[v][15:0]);
            wait_done();
            compare_log($sformatf("R1 R2 R3 R4 R5 R6 R7 R12 vec%0d", v));
            check(lg[0] == 8'h06, "R1", "first frame opcode", lg[0], 8'h06);
            check(bytes_sent == VTAB[v][15:0], "R8", "bytes_sent", bytes_sent, VTAB[v][15:0]);
            check(!error && done, "R9", "clean finish flags", {done, error}, 2'b10);
        end
        stall = 0;

        // Zero length (R10).
        launch(24'h000200, 16'd0);
        check(done && !busy && !error, "R10", "zero-length done",
              {done, busy, error}, 3'b100);
        repeat (20) @(negedge clk);
        check(lg_n == 0 && bytes_sent == 0, "R10", "zero-length frames", lg_n, 0);

        // Status timeout (R9): flash never leaves busy.
        hang = 1;
        ex_n = 0;
        push(8'h06); push(8'hAD); push_addr(24'h000040); push(pat(0)); push(pat(1));
        for (int i = 0; i < 8; i++) push(8'h05);
        launch(24'h000040, 16'd4);
        wait_done();
        repeat (40) @(negedge clk);
        compare_log("R9 timeout");
        check(error && done, "R9", "error flags", {done, error}, 2'b11);
        check(bytes_sent == 16'd2, "R9", "bytes at abort", bytes_sent, 2);
        hang = 0;

        // Reset in the middle of a run (R11).
        launch(24'h000300, 16'd9);
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy, "R11", "pins after mid-run reset",
              {spi_cs_n, spi_sclk, busy}, 3'b100);
        check(bytes_sent == 0, "R8", "count after mid-run reset", bytes_sent, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Clock never high outside a frame (R11).
        check(sclk_bad == 0, "R11", "sclk high with cs_n high", sclk_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule